// File: doc/BRIEF.md
# SPI Controller Register and FIFO Front-End

This block is the software-facing half of a serial peripheral controller. A host reaches it through a plain 32-bit register bus with an address, a write strobe, a read strobe and data. Behind the bus it keeps the enable, clock-shape, word-size and frame settings and drives them out to a shift engine. It also holds an eight-entry transmit queue and an eight-entry receive queue, a status word, three sticky event flags with enable masks, and an interrupt line.

Both queues sit behind one data address. A write there queues a transmit word, and a read there takes the oldest received word. The engine consumes transmit words over a valid/ready stream and delivers received words over a valid strobe. The shifter itself is not part of this block, and the bench stands in for it with a loopback. Flushing and level thresholds for both queues live in one control word. Event flags are cleared by writing ones to their positions.

Top module: `spi_reg_front`

## Requirements
- R1: After reset, every configuration output is 0, `irq_o` is 0, `tx_valid_o` is 0, and a read of the status word (offset 0x14) returns 0x00000020.
- R2: Configuration words write and read back through their fields only and drive the matching outputs from the next cycle. Clock word at 0x04: ratio [7:0], delay [12], idle level [13], capture edge [14]. Transmit word-size at 0x08: data length [5:0], format [7:6], word length [13:8]. Receive word-size at 0x0c: data length [5:0], format [7:6]. Frame word at 0x10: start edge [14], polarity [15]. Enable at 0x00 bit 0.
- R3: A write to offset 0x24 queues the word for transmit. `tx_valid_o` is high only while enable is 1 and the queue holds data, and words leave in the order written.
- R4: A read at offset 0x24 takes the oldest received word. `rdata_o` carries it in the cycle after the read strobe, and words come out in arrival order.
- R5: The transmit queue holds 8 words. At 8 words, status bit 5 (room to transmit) reads 0, and a further data write is ignored.
- R6: A data read while the receive queue is empty returns 0 and leaves the queue unchanged.
- R7: A received word that arrives while the receive queue holds 8 words is dropped and sets the overrun flag (bit 0 at 0x1c). The flag stays set until a 1 is written to that bit.
- R8: In the FIFO control word at 0x20, writing 1 to bit 12 empties the transmit queue and writing 1 to bit 4 empties the receive queue, each in one cycle. Both bits read as 0. The transmit threshold [11:8] and receive threshold [3:0] read back as written.
- R9: Status bit 7 mirrors `busy_i`, and status bit 0 is 1 exactly when the receive queue holds data.
- R10: The transmit-complete flag (bit 4 at 0x1c) sets when a transmit word leaves and the level left is at or below the transmit threshold. The receive-complete flag (bit 3) sets when a word is taken in and the level reaches at least the receive threshold. Each flag is cleared by writing 1 to its bit. `irq_o` is the OR of the flags masked by the enable word at 0x18, which uses the same bit positions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 8 | Register byte address |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid the cycle after `rd_i` |
| irq_o | output | 1 | Masked event interrupt |
| busy_i | input | 1 | Engine busy indication |
| tx_valid_o | output | 1 | Transmit word available |
| tx_ready_i | input | 1 | Engine takes the transmit word |
| tx_data_o | output | 32 | Transmit word |
| rx_valid_i | input | 1 | Received word strobe |
| rx_data_i | input | 32 | Received word |
| enable_o | output | 1 | Controller enable |
| clk_ratio_o | output | 8 | Serial clock divide ratio |
| cap_edge_o | output | 1 | Capture edge select |
| idle_level_o | output | 1 | Serial clock idle level |
| clk_delay_o | output | 1 | Serial clock delay select |
| frame_pol_o | output | 1 | Frame select polarity |
| frame_start_o | output | 1 | Frame start edge select |
| tx_word_len_o | output | 6 | Transmit word length |
| tx_fmt_o | output | 2 | Transmit bit-order format |
| tx_data_len_o | output | 6 | Transmit data length |
| rx_fmt_o | output | 2 | Receive bit-order format |
| rx_data_len_o | output | 6 | Receive data length |

## Verification
A register write takes effect at the clock edge that samples it, so configuration outputs, queue levels, flags and `irq_o` are due one cycle after the write strobe. Read data is registered and is due one cycle after the read strobe. A transmit word appears on the stream one cycle after enable rises and leaves at the edge where ready is high, and a flag caused by a handshake is visible in the following cycle. The bench drives inputs on falling edges and samples outputs on the next falling edge, which falls after exactly one rising edge, so each result is checked in the cycle in which it is due.

// File: rtl/spi_regs_pkg.sv
package spi_regs_pkg;
  parameter int unsigned ADDR_W  = 8;
  parameter int unsigned DATA_W  = 32;
  parameter int unsigned Q_DEPTH = 8;
  parameter int unsigned Q_CNT_W = $clog2(Q_DEPTH + 1);
  parameter int unsigned N_EVT   = 3;

  parameter logic [7:0] OFF_CTRL  = 8'h00;
  parameter logic [7:0] OFF_CLK   = 8'h04;
  parameter logic [7:0] OFF_TXWS  = 8'h08;
  parameter logic [7:0] OFF_RXWS  = 8'h0c;
  parameter logic [7:0] OFF_FRAME = 8'h10;
  parameter logic [7:0] OFF_STAT  = 8'h14;
  parameter logic [7:0] OFF_IEN   = 8'h18;
  parameter logic [7:0] OFF_ICLR  = 8'h1c;
  parameter logic [7:0] OFF_QCTL  = 8'h20;
  parameter logic [7:0] OFF_DATA  = 8'h24;

  // event vector index
  typedef enum logic [1:0] {EV_OVR = 2'd0, EV_RXC = 2'd1, EV_TXC = 2'd2} evt_e;

  typedef struct packed {
    logic [7:0] ratio;
    logic       cap_edge;
    logic       idle_lvl;
    logic       delay;
  } clk_cfg_t;
endpackage

// File: rtl/spi_fifo.sv
module spi_fifo #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned DEPTH  = 8,
  parameter int unsigned CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              flush_i,
  input  logic              push_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              pop_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [CNT_W-1:0]  count_o,
  output logic              full_o,
  output logic              empty_o
);
  localparam int unsigned PTR_W = $clog2(DEPTH);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wr_ptr, rd_ptr;
  logic              do_push, do_pop;

  assign full_o  = (count_o == CNT_W'(DEPTH));
  assign empty_o = (count_o == '0);
  assign do_push = push_i && !full_o && !flush_i;
  assign do_pop  = pop_i && !empty_o && !flush_i;
  assign rdata_o = mem[rd_ptr];

  function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  always_ff @(posedge clk_i) begin
    if (do_push) mem[wr_ptr] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      count_o <= '0;
    end else if (flush_i) begin
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      count_o <= '0;
    end else begin
      if (do_push) wr_ptr <= nxt(wr_ptr);
      if (do_pop)  rd_ptr <= nxt(rd_ptr);
      count_o <= count_o + CNT_W'(do_push) - CNT_W'(do_pop);
    end
  end

  // R5
  fifo_cap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_o <= CNT_W'(DEPTH));
  // R5
  fifo_full_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && push_i && !pop_i && !flush_i) |=> $stable(count_o));
  // R8
  fifo_flush_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> empty_o);
endmodule

// File: rtl/spi_evt_flags.sv
module spi_evt_flags #(
  parameter int unsigned N = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  input  logic [N-1:0] mask_i,
  output logic [N-1:0] flag_o,
  output logic         irq_o
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       flag_o[i] <= 1'b0;
      else if (set_i[i]) flag_o[i] <= 1'b1;  // new event beats clear
      else if (clr_i[i]) flag_o[i] <= 1'b0;
    end

    // R7
    flag_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (flag_o[i] && !clr_i[i]) |=> flag_o[i]);
  end

  assign irq_o = |(flag_o & mask_i);
endmodule

// File: rtl/spi_reg_front.sv
module spi_reg_front
  import spi_regs_pkg::*;
#(
  parameter int unsigned AW    = ADDR_W,
  parameter int unsigned DW    = DATA_W,
  parameter int unsigned DEPTH = Q_DEPTH
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] addr_i,
  input  logic          wr_i,
  input  logic          rd_i,
  input  logic [31:0]   wdata_i,
  output logic [31:0]   rdata_o,
  output logic          irq_o,
  input  logic          busy_i,
  output logic          tx_valid_o,
  input  logic          tx_ready_i,
  output logic [DW-1:0] tx_data_o,
  input  logic          rx_valid_i,
  input  logic [DW-1:0] rx_data_i,
  output logic          enable_o,
  output logic [7:0]    clk_ratio_o,
  output logic          cap_edge_o,
  output logic          idle_level_o,
  output logic          clk_delay_o,
  output logic          frame_pol_o,
  output logic          frame_start_o,
  output logic [5:0]    tx_word_len_o,
  output logic [1:0]    tx_fmt_o,
  output logic [5:0]    tx_data_len_o,
  output logic [1:0]    rx_fmt_o,
  output logic [5:0]    rx_data_len_o
);
  localparam int unsigned CW = $clog2(DEPTH + 1);

  function automatic logic hit(input logic [AW-1:0] a, input logic [7:0] off);
    return a == AW'(off);
  endfunction

  clk_cfg_t        clk_q;
  logic [3:0]      tx_thr_q, rx_thr_q;
  logic [N_EVT-1:0] ien_q, flags, ev_set, ev_clr;
  logic            en_q;
  logic [31:0]     rd_mux;

  logic            tx_full, tx_empty, rx_full, rx_empty;
  logic [CW-1:0]   tx_cnt, rx_cnt;
  logic [DW-1:0]   rx_head;
  logic            tx_flush, rx_flush, tx_push, tx_pop, rx_push, rx_pop;
  logic [CW:0]     tx_lvl_next, rx_lvl_next;

  wire wr_ctl = wr_i && hit(addr_i, OFF_QCTL);
  assign tx_flush = wr_ctl && wdata_i[12];
  assign rx_flush = wr_ctl && wdata_i[4];
  assign tx_push  = wr_i && hit(addr_i, OFF_DATA) && !tx_full && !tx_flush;
  assign tx_valid_o = en_q && !tx_empty;
  assign tx_pop   = tx_valid_o && tx_ready_i && !tx_flush;
  assign rx_push  = rx_valid_i && !rx_full && !rx_flush;
  assign rx_pop   = rd_i && hit(addr_i, OFF_DATA) && !rx_empty && !rx_flush;

  spi_fifo #(.DATA_W(DW), .DEPTH(DEPTH), .CNT_W(CW)) u_txq (
    .clk_i, .rst_ni, .flush_i(tx_flush), .push_i(tx_push), .wdata_i(wdata_i[DW-1:0]),
    .pop_i(tx_pop), .rdata_o(tx_data_o), .count_o(tx_cnt), .full_o(tx_full),
    .empty_o(tx_empty));

  spi_fifo #(.DATA_W(DW), .DEPTH(DEPTH), .CNT_W(CW)) u_rxq (
    .clk_i, .rst_ni, .flush_i(rx_flush), .push_i(rx_push), .wdata_i(rx_data_i),
    .pop_i(rx_pop), .rdata_o(rx_head), .count_o(rx_cnt), .full_o(rx_full),
    .empty_o(rx_empty));

  // levels left after this cycle's traffic
  assign tx_lvl_next = {1'b0, tx_cnt} + (CW+1)'(tx_push) - (CW+1)'(tx_pop);
  assign rx_lvl_next = {1'b0, rx_cnt} + (CW+1)'(rx_push) - (CW+1)'(rx_pop);

  always_comb begin
    ev_set         = '0;
    ev_set[EV_TXC] = tx_pop && (int'(tx_lvl_next) <= int'(tx_thr_q));
    ev_set[EV_RXC] = rx_push && (int'(rx_lvl_next) >= int'(rx_thr_q));
    ev_set[EV_OVR] = rx_valid_i && rx_full;
    ev_clr         = '0;
    if (wr_i && hit(addr_i, OFF_ICLR)) ev_clr = {wdata_i[4], wdata_i[3], wdata_i[0]};
  end

  spi_evt_flags #(.N(N_EVT)) u_evt (
    .clk_i, .rst_ni, .set_i(ev_set), .clr_i(ev_clr), .mask_i(ien_q),
    .flag_o(flags), .irq_o(irq_o));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q <= 1'b0;  clk_q <= '0;
      tx_word_len_o <= '0; tx_fmt_o <= '0; tx_data_len_o <= '0;
      rx_fmt_o <= '0; rx_data_len_o <= '0;
      frame_pol_o <= 1'b0; frame_start_o <= 1'b0;
      ien_q <= '0; tx_thr_q <= '0; rx_thr_q <= '0;
    end else if (wr_i) begin
      if (hit(addr_i, OFF_CTRL)) en_q <= wdata_i[0];
      if (hit(addr_i, OFF_CLK))
        clk_q <= '{ratio: wdata_i[7:0], cap_edge: wdata_i[14],
                   idle_lvl: wdata_i[13], delay: wdata_i[12]};
      if (hit(addr_i, OFF_TXWS)) begin
        tx_word_len_o <= wdata_i[13:8];
        tx_fmt_o      <= wdata_i[7:6];
        tx_data_len_o <= wdata_i[5:0];
      end
      if (hit(addr_i, OFF_RXWS)) begin
        rx_fmt_o      <= wdata_i[7:6];
        rx_data_len_o <= wdata_i[5:0];
      end
      if (hit(addr_i, OFF_FRAME)) begin
        frame_pol_o   <= wdata_i[15];
        frame_start_o <= wdata_i[14];
      end
      if (hit(addr_i, OFF_IEN)) ien_q <= {wdata_i[4], wdata_i[3], wdata_i[0]};
      if (wr_ctl) begin
        tx_thr_q <= wdata_i[11:8];
        rx_thr_q <= wdata_i[3:0];
      end
    end
  end

  assign enable_o     = en_q;
  assign clk_ratio_o  = clk_q.ratio;
  assign cap_edge_o   = clk_q.cap_edge;
  assign idle_level_o = clk_q.idle_lvl;
  assign clk_delay_o  = clk_q.delay;

  always_comb begin
    rd_mux = '0;
    unique case (1'b1)
      hit(addr_i, OFF_CTRL):  rd_mux[0] = en_q;
      hit(addr_i, OFF_CLK):   rd_mux = {17'b0, clk_q.cap_edge, clk_q.idle_lvl, clk_q.delay,
                                        4'b0, clk_q.ratio};
      hit(addr_i, OFF_TXWS):  rd_mux = {18'b0, tx_word_len_o, tx_fmt_o, tx_data_len_o};
      hit(addr_i, OFF_RXWS):  rd_mux = {24'b0, rx_fmt_o, rx_data_len_o};
      hit(addr_i, OFF_FRAME): rd_mux = {16'b0, frame_pol_o, frame_start_o, 14'b0};
      hit(addr_i, OFF_STAT):  rd_mux = {24'b0, busy_i, 1'b0, !tx_full, 4'b0, !rx_empty};
      hit(addr_i, OFF_IEN):   rd_mux = {27'b0, ien_q[EV_TXC], ien_q[EV_RXC], 2'b0, ien_q[EV_OVR]};
      hit(addr_i, OFF_ICLR):  rd_mux = {27'b0, flags[EV_TXC], flags[EV_RXC], 2'b0, flags[EV_OVR]};
      hit(addr_i, OFF_QCTL):  rd_mux = {20'b0, tx_thr_q, 4'b0, rx_thr_q};
      hit(addr_i, OFF_DATA):  rd_mux = rx_empty ? '0 : 32'(rx_head);
      default:                rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_o <= '0;
    else if (rd_i) rdata_o <= rd_mux;
  end

  // R3
  tx_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o |-> enable_o);
  // R6
  empty_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && hit(addr_i, OFF_DATA) && rx_empty) |=> (rdata_o == '0 && $stable(rx_cnt)));
  // R7
  overrun_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_valid_i && rx_full) |=> flags[EV_OVR]);
  // R9
  busy_stat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && hit(addr_i, OFF_STAT)) |=> (rdata_o[7] == $past(busy_i)));
endmodule

// File: tb/tb_spi_reg_front.sv
module tb_spi_reg_front;
  localparam logic [31:0] LOOP_XOR = 32'hA5A5_0000;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic [7:0]  addr = '0;
  logic        wr = 1'b0, rd = 1'b0, busy = 1'b0, tx_ready = 1'b0;
  logic [31:0] wdata = '0, rdata, tx_data, rx_data, drv_rx_data = '0;
  logic        irq, tx_valid, rx_valid, drv_rx_valid = 1'b0, loop_en = 1'b0;
  logic        en, cap, idle, dly, fpol, fstart;
  logic [7:0]  ratio;
  logic [5:0]  twl, tdl, rdl;
  logic [1:0]  tfmt, rfmt;

  int vectors = 0, fails = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  assign rx_valid = loop_en ? (tx_valid && tx_ready) : drv_rx_valid;
  assign rx_data  = loop_en ? (tx_data ^ LOOP_XOR) : drv_rx_data;

  spi_reg_front dut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_i(wr), .rd_i(rd),
    .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq), .busy_i(busy),
    .tx_valid_o(tx_valid), .tx_ready_i(tx_ready), .tx_data_o(tx_data),
    .rx_valid_i(rx_valid), .rx_data_i(rx_data), .enable_o(en),
    .clk_ratio_o(ratio), .cap_edge_o(cap), .idle_level_o(idle), .clk_delay_o(dly),
    .frame_pol_o(fpol), .frame_start_o(fstart), .tx_word_len_o(twl),
    .tx_fmt_o(tfmt), .tx_data_len_o(tdl), .rx_fmt_o(rfmt), .rx_data_len_o(rdl));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic bus_rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; rd = 1'b1;
    @(negedge clk); rd = 1'b0; d = rdata;
  endtask

  task automatic idle_cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [31:0] d;
    chk("R1 irq", 32'(irq), 0);
    chk("R1 cfg outs", {en, ratio, cap, idle, dly, fpol, fstart, twl, tfmt, tdl, rfmt, rdl}, 0);
    chk("R1 tx_valid", 32'(tx_valid), 0);
    bus_rd(8'h14, d); chk("R1 status", d, 32'h20);
  endtask

  task automatic t_config;
    logic [31:0] d;
    bus_wr(8'h04, 32'hFFFF_FFFF);
    bus_rd(8'h04, d); chk("R2 clock readback", d, 32'h70FF);
    bus_wr(8'h04, 32'h0000_4012);
    chk("R2 clock outs", {ratio, cap, idle, dly}, {8'h12, 3'b100});
    bus_wr(8'h08, 32'h0000_1F48);
    bus_rd(8'h08, d); chk("R2 txws readback", d, 32'h1F48);
    chk("R2 txws outs", {twl, tfmt, tdl}, {6'h1F, 2'd1, 6'h08});
    bus_wr(8'h0c, 32'hFFFF_FF90);
    bus_rd(8'h0c, d); chk("R2 rxws readback", d, 32'h90);
    chk("R2 rxws outs", {rfmt, rdl}, {2'd2, 6'h10});
    bus_wr(8'h10, 32'h0000_8000);
    bus_rd(8'h10, d); chk("R2 frame readback", d, 32'h8000);
    chk("R2 frame outs", {fpol, fstart}, 2'b10);
    bus_wr(8'h00, 32'h1); chk("R2 enable out", 32'(en), 1);
    bus_wr(8'h00, 32'h0);
  endtask

  task automatic t_order;
    logic [31:0] d, got [$];
    bus_wr(8'h24, 32'h11); bus_wr(8'h24, 32'h22); bus_wr(8'h24, 32'h33);
    idle_cycles(2);
    chk("R3 no stream while disabled", 32'(tx_valid), 0);
    loop_en = 1'b1; tx_ready = 1'b1;
    bus_wr(8'h00, 32'h1);
    for (int i = 0; i < 6; i++) begin
      if (tx_valid) got.push_back(tx_data);
      @(negedge clk);
    end
    chk("R3 stream count", got.size(), 3);
    for (int i = 0; i < got.size(); i++) chk("R3 stream order", got[i], 32'h11 * (i + 1));
    loop_en = 1'b0; tx_ready = 1'b0;
    bus_wr(8'h00, 32'h0);
    bus_rd(8'h14, d); chk("R9 rx not empty", d & 32'h1, 1);
    for (int i = 0; i < 3; i++) begin
      bus_rd(8'h24, d); chk("R4 rx order", d, (32'h11 * (i + 1)) ^ LOOP_XOR);
    end
    bus_rd(8'h24, d); chk("R6 empty read", d, 0);
    bus_rd(8'h14, d); chk("R6 still empty", d & 32'h1, 0);
  endtask

  task automatic t_full;
    logic [31:0] d, got [$];
    for (int i = 0; i < 8; i++) bus_wr(8'h24, 32'h100 + i);
    bus_rd(8'h14, d); chk("R5 no room at 8", d, 32'h0);
    bus_wr(8'h24, 32'hDEAD);
    loop_en = 1'b1; tx_ready = 1'b1;
    bus_wr(8'h00, 32'h1);
    for (int i = 0; i < 12; i++) begin
      if (tx_valid) got.push_back(tx_data);
      @(negedge clk);
    end
    chk("R5 extra write dropped", got.size(), 8);
    chk("R5 last word", got[got.size() - 1], 32'h107);
    loop_en = 1'b0; tx_ready = 1'b0;
    bus_wr(8'h00, 32'h0);
    bus_wr(8'h20, 32'h10);
    bus_rd(8'h14, d); chk("R8 rx flush", d & 32'h1, 0);
  endtask

  task automatic t_overrun;
    logic [31:0] d;
    bus_wr(8'h1c, 32'h19);
    for (int i = 0; i < 9; i++) begin
      @(negedge clk); drv_rx_valid = 1'b1; drv_rx_data = 32'h200 + i;
    end
    @(negedge clk); drv_rx_valid = 1'b0;
    bus_rd(8'h1c, d); chk("R7 overrun set", d & 32'h1, 1);
    for (int i = 0; i < 8; i++) begin
      bus_rd(8'h24, d); chk("R7 kept words", d, 32'h200 + i);
    end
    bus_rd(8'h24, d); chk("R7 ninth dropped", d, 0);
    bus_rd(8'h1c, d); chk("R7 overrun sticky", d & 32'h1, 1);
    bus_wr(8'h1c, 32'h1);
    bus_rd(8'h1c, d); chk("R7 overrun cleared", d & 32'h1, 0);
  endtask

  task automatic t_flush;
    logic [31:0] d;
    for (int i = 0; i < 4; i++) bus_wr(8'h24, 32'h300 + i);
    bus_wr(8'h20, 32'h1305);
    bus_rd(8'h20, d); chk("R8 qctl readback", d, 32'h0305);
    tx_ready = 1'b1;
    bus_wr(8'h00, 32'h1);
    idle_cycles(2);
    chk("R8 tx flushed", 32'(tx_valid), 0);
    bus_rd(8'h14, d); chk("R8 tx room", d & 32'h20, 32'h20);
    tx_ready = 1'b0;
    bus_wr(8'h00, 32'h0);
  endtask

  task automatic t_busy;
    logic [31:0] d;
    busy = 1'b1;
    bus_rd(8'h14, d); chk("R9 busy high", d & 32'h80, 32'h80);
    busy = 1'b0;
    bus_rd(8'h14, d); chk("R9 busy low", d & 32'h80, 0);
  endtask

  task automatic t_events;
    logic [31:0] d;
    bus_wr(8'h20, 32'h0003);
    bus_wr(8'h1c, 32'h19);
    bus_wr(8'h24, 32'h41); bus_wr(8'h24, 32'h42);
    loop_en = 1'b1; tx_ready = 1'b1;
    bus_wr(8'h00, 32'h1);
    idle_cycles(3);
    bus_rd(8'h1c, d); chk("R10 tx done, rx below thr", d, 32'h10);
    chk("R10 masked irq", 32'(irq), 0);
    bus_wr(8'h24, 32'h43);
    idle_cycles(2);
    bus_rd(8'h1c, d); chk("R10 rx reaches thr", d, 32'h18);
    bus_wr(8'h18, 32'h08);
    chk("R10 irq on", 32'(irq), 1);
    bus_wr(8'h1c, 32'h08);
    bus_rd(8'h1c, d); chk("R10 rx flag cleared", d, 32'h10);
    chk("R10 irq off", 32'(irq), 0);
    loop_en = 1'b0; tx_ready = 1'b0;
    bus_wr(8'h00, 32'h0);
  endtask

  task automatic finish_run;
    if (!finished) begin
      finished = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_config;
    t_order;
    t_full;
    t_overrun;
    t_flush;
    t_busy;
    t_events;
    finish_run;
  end

  initial begin
    repeat (20000) @(posedge clk);
    vectors++; fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run;
  end
endmodule